// File: doc/BRIEF.md
# Macropixel sparsified hit readout controller

This block sits at the edge of a binary pixel matrix whose pixels are grouped into square macropixels of 4x4. Every macropixel owns a private hit line into the block. A pulse on that line marks the macropixel as pending and stores the value of a local 8-bit timestamp counter. The counter steps once for every cycle in which a beam-crossing strobe is high, and wraps from 255 back to 0.

A fixed-priority scan then serves the pending macropixels one at a time, lowest index first. The selected macropixel is placed on a shared enable/address pair. Its 16 pixel bits come back on a shared data bus. Zero pixels are dropped. Each set pixel becomes one output word `{timestamp, row, column}`, passed out through a valid/ready handshake.

A hit that arrives on a macropixel that is already pending is held as a second event with its own timestamp, and is served after the first read finishes. Any further hits fold into that held event. The matrix size is set by parameters; the default is 32 columns by 128 rows, which gives 256 macropixels.

The controller is a four-state machine:
- `ST_IDLE` waits for any pending macropixel and latches the winner of the scan (IDLE→ENABLE).
- `ST_ENABLE` drives the enable for one cycle (ENABLE→CAPTURE).
- `ST_CAPTURE` keeps the enable high, samples the bus and clears the pending entry. It goes to EMIT when the sampled data is non-zero (CAPTURE→EMIT), and back to IDLE when it is zero (CAPTURE→IDLE).
- `ST_EMIT` offers one word per set pixel. It stays in EMIT until the last word is accepted (EMIT→EMIT), then returns to IDLE (EMIT→IDLE).

Top module: `mpro_readout`

## Requirements
- R1: While reset is asserted and after it is released, `rd_en` and `out_valid` are 0 and the timestamp counter holds 0. A hit taken before any strobe therefore carries timestamp 0.
- R2: The timestamp increases by one after each cycle in which `bco_tick` is 1, wrapping from 255 to 0. A hit in the same cycle as a strobe takes the value from before the increment.
- R3: A hit pulse on a macropixel that is not pending makes it pending, with the timestamp value of that cycle.
- R4: From `ST_IDLE`, the pending macropixel with the lowest index is read. `rd_en` is high for exactly two cycles while `rd_addr` holds that index, and `pix_data` is sampled in the second of those cycles.
- R5: A read emits one word per set bit of `pix_data`, in ascending bit order. Bit b of macropixel m maps to row = (m / (COLS/4))·4 + b/4 and column = (m mod (COLS/4))·4 + b mod 4. The word is {timestamp[7:0], row, column}, with the column in the least significant bits.
- R6: A read that returns all zeros emits no word, and the macropixel is no longer pending, so it is not read again.
- R7: A hit on a macropixel that is already pending is kept as a second event with its own timestamp and is read after the first. Further hits before that second read fold into it: their pixels appear in it, and their timestamps are discarded.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_word` is unchanged.
- R9: With every pixel of every macropixel hit at once, each pixel gives exactly one word, none lost and none repeated.
- R10: All words of one read are accepted before the next `rd_en` rises, and `rd_en` and `out_valid` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bco_tick | input | 1 | One-cycle beam-crossing strobe; advances the timestamp |
| mp_hit | input | NMP | One hit pulse line per macropixel |
| rd_en | output | 1 | Shared enable for the selected macropixel |
| rd_addr | output | MPA_W | Index of the enabled macropixel |
| pix_data | input | 16 | Shared pixel bus from the enabled macropixel |
| out_valid | output | 1 | Output word available |
| out_ready | input | 1 | Consumer accepts the word |
| out_word | output | WORD_W | {timestamp, row, column} |

## Verification
The assertions assume the following about the inputs. `pix_data` is a stable function of `rd_addr` through the second enable cycle. `bco_tick` and `mp_hit` are driven between clock edges. The consumer may withhold `out_ready` for any length of time.

The bench models the matrix as a two-deep event store per macropixel, and folds a third hit into the second event exactly as R7 defines. It drives the bus only from the event that is being read, and holds that value from the first enable cycle until the capture edge. Every pattern of hits, ticks and ready is therefore legal, including hits that land in the very cycle their macropixel is captured.

// File: rtl/mpro_pkg.sv
package mpro_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ENABLE,
        ST_CAPTURE,
        ST_EMIT
    } rd_state_e;
endpackage

// File: rtl/mpro_tstamp.sv
module mpro_tstamp #(
    parameter int TS_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    output logic [TS_W-1:0] ts
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ts <= '0;
        else if (tick)
            ts <= ts + TS_W'(1);
    end
endmodule

// File: rtl/mpro_registry.sv
module mpro_registry #(
    parameter int NMP   = 256,
    parameter int MPA_W = 8,
    parameter int TS_W  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NMP-1:0]       hit,
    input  logic [TS_W-1:0]      ts_now,
    input  logic                 clr_en,
    input  logic [MPA_W-1:0]     clr_idx,
    output logic [NMP-1:0]       pend,
    output logic [NMP*TS_W-1:0]  ts_flat
);
    for (genvar g = 0; g < NMP; g++) begin : g_mp
        logic            pend_q;
        logic            held_q;
        logic [TS_W-1:0] ts_q;
        logic [TS_W-1:0] hts_q;
        logic            clr;

        assign clr = clr_en && (clr_idx == MPA_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend_q <= 1'b0;
                held_q <= 1'b0;
                ts_q   <= '0;
                hts_q  <= '0;
            end else if (clr) begin
                if (held_q) begin
                    // promote the held event, a fresh hit becomes the new held one
                    pend_q <= 1'b1;
                    ts_q   <= hts_q;
                    held_q <= hit[g];
                    if (hit[g])
                        hts_q <= ts_now;
                end else begin
                    pend_q <= hit[g];
                    if (hit[g])
                        ts_q <= ts_now;
                end
            end else if (hit[g]) begin
                if (!pend_q) begin
                    pend_q <= 1'b1;
                    ts_q   <= ts_now;
                end else if (!held_q) begin
                    held_q <= 1'b1;
                    hts_q  <= ts_now;
                end
            end
        end

        assign pend[g]                  = pend_q;
        assign ts_flat[g*TS_W +: TS_W]  = ts_q;
    end
endmodule

// File: rtl/mpro_arbiter.sv
module mpro_arbiter #(
    parameter int NMP   = 256,
    parameter int MPA_W = 8
) (
    input  logic [NMP-1:0]   req,
    output logic             any,
    output logic [MPA_W-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = NMP - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = MPA_W'(i);
            end
        end
    end
endmodule

// File: rtl/mpro_readout.sv
module mpro_readout
    import mpro_pkg::*;
#(
    parameter int COLS    = 32,
    parameter int ROWS    = 128,
    parameter int MP_COLS = 4,
    parameter int MP_ROWS = 4,
    parameter int TS_W    = 8,
    localparam int MPC    = COLS / MP_COLS,
    localparam int NMP    = MPC * (ROWS / MP_ROWS),
    localparam int MPA_W  = (NMP > 1) ? $clog2(NMP) : 1,
    localparam int MP_PIX = MP_COLS * MP_ROWS,
    localparam int ROW_W  = $clog2(ROWS),
    localparam int COL_W  = $clog2(COLS),
    localparam int WORD_W = TS_W + ROW_W + COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bco_tick,
    input  logic [NMP-1:0]    mp_hit,
    output logic              rd_en,
    output logic [MPA_W-1:0]  rd_addr,
    input  logic [MP_PIX-1:0] pix_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_word
);
    rd_state_e          state, nxt;
    logic [TS_W-1:0]    ts_now;
    logic [NMP-1:0]     pend;
    logic [NMP*TS_W-1:0] ts_flat;
    logic               pick_any;
    logic [MPA_W-1:0]   pick_idx;
    logic [MPA_W-1:0]   cur_idx;
    logic [TS_W-1:0]    cur_ts;
    logic [MP_PIX-1:0]  bits;
    logic [MP_PIX-1:0]  bits_rest;
    logic               clr_en;
    int                 bi;
    int                 mr;
    int                 mc;

    mpro_tstamp #(.TS_W(TS_W)) u_tstamp (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (bco_tick),
        .ts    (ts_now)
    );

    assign clr_en = (state == ST_CAPTURE);

    mpro_registry #(.NMP(NMP), .MPA_W(MPA_W), .TS_W(TS_W)) u_registry (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (mp_hit),
        .ts_now  (ts_now),
        .clr_en  (clr_en),
        .clr_idx (cur_idx),
        .pend    (pend),
        .ts_flat (ts_flat)
    );

    mpro_arbiter #(.NMP(NMP), .MPA_W(MPA_W)) u_arbiter (
        .req (pend),
        .any (pick_any),
        .idx (pick_idx)
    );

    // remaining pixels once the lowest one is sent
    assign bits_rest = bits & (bits - MP_PIX'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (pick_any) nxt = ST_ENABLE;
            ST_ENABLE:  nxt = ST_CAPTURE;
            ST_CAPTURE: nxt = (pix_data != '0) ? ST_EMIT : ST_IDLE;
            ST_EMIT:    if (out_ready && (bits_rest == '0)) nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_idx <= '0;
            cur_ts  <= '0;
            bits    <= '0;
        end else begin
            if (state == ST_IDLE && pick_any)
                cur_idx <= pick_idx;
            if (state == ST_CAPTURE) begin
                bits   <= pix_data;
                cur_ts <= ts_flat[cur_idx*TS_W +: TS_W];
            end
            if (state == ST_EMIT && out_ready)
                bits <= bits_rest;
        end
    end

    // lowest set pixel of the captured macropixel
    always_comb begin
        bi = 0;
        for (int i = MP_PIX - 1; i >= 0; i--)
            if (bits[i]) bi = i;
    end

    // outputs
    always_comb begin
        mr        = int'(cur_idx) / MPC;
        mc        = int'(cur_idx) % MPC;
        rd_en     = (state == ST_ENABLE) || (state == ST_CAPTURE);
        rd_addr   = cur_idx;
        out_valid = (state == ST_EMIT);
        out_word  = {cur_ts,
                     ROW_W'(mr * MP_ROWS + bi / MP_COLS),
                     COL_W'(mc * MP_COLS + bi % MP_COLS)};
    end
endmodule

// File: rtl/mpro_readout_chk.sv
module mpro_readout_chk #(
    parameter int MPA_W  = 8,
    parameter int WORD_W = 20,
    parameter int TS_W   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bco_tick,
    input logic              rd_en,
    input logic [MPA_W-1:0]  rd_addr,
    input logic              out_valid,
    input logic              out_ready,
    input logic [WORD_W-1:0] out_word,
    input logic [TS_W-1:0]   ts_now
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!rd_en && !out_valid && ts_now == '0));

    // R2
    ts_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bco_tick |=> (ts_now == $past(ts_now) + TS_W'(1)));

    // R2
    ts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bco_tick |=> $stable(ts_now));

    // R4
    rd_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_en) |=> (rd_en && $stable(rd_addr)));

    // R4
    rd_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && $past(rd_en)) |=> !rd_en);

    // R8
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

    // R10
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && out_valid));
endmodule

bind mpro_readout mpro_readout_chk #(
    .MPA_W  (MPA_W),
    .WORD_W (WORD_W),
    .TS_W   (TS_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bco_tick  (bco_tick),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_word  (out_word),
    .ts_now    (ts_now)
);

// File: tb/test_mpro_readout.sv
`timescale 1ns/1ps
module test_mpro_readout;
    localparam int COLS = 8, ROWS = 8, MPC = 2, NMP = 4, MPA_W = 2;
    localparam int TS_W = 8, ROW_W = 3, COL_W = 3, WORD_W = 14;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic              rst_n = 1'b0;
    logic              bco_tick = 1'b0;
    logic [NMP-1:0]    mp_hit = '0;
    logic              rd_en;
    logic [MPA_W-1:0]  rd_addr;
    logic [15:0]       pix_data = '0;
    logic              out_valid;
    logic              out_ready = 1'b0;
    logic [WORD_W-1:0] out_word;

    mpro_readout #(.COLS(COLS), .ROWS(ROWS)) i_mpro_readout (
        .clk(clk), .rst_n(rst_n), .bco_tick(bco_tick), .mp_hit(mp_hit),
        .rd_en(rd_en), .rd_addr(rd_addr), .pix_data(pix_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word)
    );

    int compared = 0, mismatched = 0;
    logic [TS_W-1:0] bts = '0;
    logic [15:0] q_pat [NMP][2];
    logic [7:0]  q_ts  [NMP][2];
    int          q_len [NMP];
    logic [WORD_W-1:0] exp_w [64];
    int exp_rd = 0, exp_n = 0;
    logic [NMP-1:0] st_hit = '0;
    logic [15:0] st_pat [NMP];
    logic st_tick = 1'b0;
    int rdy_mode = 0, tick_rate = 0;
    int rd_cycle = 0, reads_total = 0, words_total = 0;
    logic [NMP-1:0] snap = '0;
    bit prev_stall = 0;
    logic [WORD_W-1:0] prev_word = '0;
    string ptag = "R3";

    task automatic chk(bit ok, string req, string what, longint act, longint expv);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic pop_event(int m);
        logic [15:0] p = q_pat[m][0];
        for (int b = 0; b < 16; b++) begin
            if (p[b]) begin
                exp_w[(exp_rd + exp_n) % 64] = {q_ts[m][0],
                    ROW_W'((m / MPC) * 4 + b / 4), COL_W'((m % MPC) * 4 + b % 4)};
                exp_n++;
            end
        end
        q_pat[m][0] = q_pat[m][1];
        q_ts[m][0]  = q_ts[m][1];
        q_len[m]--;
    endtask

    task automatic push_event(int m, logic [15:0] p);
        if (q_len[m] == 2) q_pat[m][1] = q_pat[m][1] | p;
        else begin
            q_pat[m][q_len[m]] = p;
            q_ts[m][q_len[m]]  = bts;
            q_len[m]++;
        end
    endtask

    task automatic step();
        int low;
        @(negedge clk);
        if (tick_rate > 0 && ($urandom % tick_rate) == 0) st_tick = 1'b1;
        case (rdy_mode)
            0: out_ready = 1'b1;
            1: out_ready = 1'b0;
            default: out_ready = (($urandom % 4) != 0);
        endcase
        if (prev_stall)
            chk(out_valid && out_word == prev_word, "R8", "stalled word",
                {out_valid, out_word}, {1'b1, prev_word});
        if (out_valid && out_ready) begin
            words_total++;
            if (exp_n == 0) chk(0, {"R5/", ptag}, "unexpected word", out_word, 0);
            else begin
                chk(out_word == exp_w[exp_rd], {"R5/", ptag}, "word", out_word, exp_w[exp_rd]);
                exp_rd = (exp_rd + 1) % 64;
                exp_n--;
            end
        end
        prev_stall = out_valid && !out_ready;
        prev_word  = out_word;
        chk(!(rd_en && out_valid), "R10", "rd_en with out_valid", {rd_en, out_valid}, 0);
        if (rd_en) begin
            if (rd_cycle == 0) begin
                low = -1;
                for (int m = NMP - 1; m >= 0; m--) if (snap[m]) low = m;
                chk(low >= 0 && int'(rd_addr) == low, "R4", "selected index", rd_addr, low);
                chk(exp_n == 0, "R10", "read before words drained", exp_n, 0);
                pix_data = (q_len[rd_addr] > 0) ? q_pat[rd_addr][0] : 16'h0;
                rd_cycle = 1;
            end else if (rd_cycle == 1) begin
                if (q_len[rd_addr] > 0) pop_event(int'(rd_addr));
                else chk(0, "R6", "read of macropixel with no event", rd_addr, 0);
                reads_total++;
                rd_cycle = 2;
            end else begin
                chk(0, "R4", "enable longer than two cycles", rd_cycle + 1, 2);
            end
        end else begin
            pix_data = '0;
            rd_cycle = 0;
        end
        for (int m = 0; m < NMP; m++) snap[m] = (q_len[m] != 0);
        for (int m = 0; m < NMP; m++) if (st_hit[m]) push_event(m, st_pat[m]);
        mp_hit   = st_hit;
        bco_tick = st_tick;
        if (st_tick) bts = bts + 8'd1;
        st_hit  = '0;
        st_tick = 1'b0;
    endtask

    task automatic drain();
        int quiet = 0, n = 0;
        bit idle;
        if (rdy_mode == 1) rdy_mode = 2;
        while (quiet < 4 && n < 3000) begin
            step();
            idle = !rd_en && !out_valid && exp_n == 0;
            for (int m = 0; m < NMP; m++) if (q_len[m] != 0) idle = 0;
            quiet = idle ? quiet + 1 : 0;
            n++;
        end
        chk(quiet >= 4, {"R9/", ptag}, "drain", n, 0);
    endtask

    task automatic stage(int m, logic [15:0] p);
        st_hit[m] = 1'b1;
        st_pat[m] = p;
    endtask

    initial begin
        #1500000;
        mismatched++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        int r0, w0;
        for (int m = 0; m < NMP; m++) begin q_len[m] = 0; st_pat[m] = '0; end
        repeat (3) @(negedge clk);
        chk(!rd_en && !out_valid, "R1", "outputs in reset", {rd_en, out_valid}, 0);
        rst_n = 1'b1;
        step();
        chk(!rd_en && !out_valid, "R1", "outputs after reset", {rd_en, out_valid}, 0);

        // R1: first hit before any strobe carries timestamp 0
        ptag = "R1";
        stage(1, 16'h0001);
        drain();

        // R3 R5: every macropixel alone, several patterns, ticks running
        ptag = "R3";
        tick_rate = 3;
        for (int m = 0; m < NMP; m++) begin
            stage(m, 16'h8000); drain();
            stage(m, 16'hA5C3); drain();
            stage(m, 16'h0410); drain();
        end

        // R4: all four at once, reads in ascending index
        ptag = "R4";
        stage(3, 16'h0003); stage(1, 16'h0100); stage(2, 16'hF000); stage(0, 16'h0008);
        drain();

        // R6: zero data clears without words
        ptag = "R6";
        r0 = reads_total; w0 = words_total;
        stage(2, 16'h0000); stage(1, 16'h0000); stage(3, 16'h0042);
        drain();
        chk(reads_total - r0 == 3, "R6", "reads for zero macropixels", reads_total - r0, 3);
        chk(words_total - w0 == 2, "R6", "words for zero macropixels", words_total - w0, 2);

        // R7: held second event and merged third hit
        ptag = "R7";
        r0 = reads_total;
        rdy_mode = 1;
        stage(0, 16'h0011); stage(1, 16'h0022); stage(2, 16'h0044); stage(3, 16'h0088);
        repeat (8) step();
        stage(1, 16'h1000); step();
        stage(1, 16'h0001); step();
        stage(2, 16'h2000); step();
        repeat (3) step();
        drain();
        chk(reads_total - r0 == 6, "R7", "reads with held events", reads_total - r0, 6);

        // R9: full occupancy under random backpressure
        ptag = "R9";
        rdy_mode = 2;
        w0 = words_total;
        for (int m = 0; m < NMP; m++) stage(m, 16'hFFFF);
        drain();
        chk(words_total - w0 == NMP * 16, "R9", "words at full occupancy", words_total - w0, NMP * 16);

        // R2: wrap the timestamp, then hit in a strobe cycle
        ptag = "R2";
        tick_rate = 0;
        for (int i = 0; i < 300; i++) begin st_tick = 1'b1; step(); end
        st_tick = 1'b1; stage(2, 16'h0101);
        drain();

        // random traffic
        ptag = "R7";
        tick_rate = 2;
        for (int i = 0; i < 4000; i++) begin
            for (int m = 0; m < NMP; m++)
                if (($urandom % 16) == 0) stage(m, 16'($urandom) & 16'($urandom));
            step();
        end
        drain();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule